// File: doc/BRIEF.md
# Microcontroller reset qualifier and low-power mode controller

This block sits beside a small 8-bit processor core and owns two jobs: deciding when the external reset pin counts as a real reset, and running the two reduced-power modes. The reset pin is brought into the oscillator clock domain, and a core reset is raised only after the pin has stayed high for two machine cycles of twelve oscillator periods each. The block also produces the machine clock, a divide-by-two of the oscillator input, so the duty cycle of that input plays no part.

Software selects a mode by writing a two-bit power-control value. In idle, the CPU clock enable drops while peripheral clocks keep running, and any enabled interrupt request returns the core to normal execution. In power-down, the oscillator-run enable drops as well, and only a qualified reset brings the core back. Interrupts have no effect in that mode. While either mode is active, the block supplies forced levels for the address-latch and program-fetch strobes, and it tells the port logic whether port 0 must float and whether port 2 keeps driving its address. Both choices depend on whether program memory is external.

Top module: `mcu_power_ctrl`

## Requirements
- R1: While powerOnRstN is low, coreRst is 1 and cpuClkEn is 0. After release with rstPin low, coreRst falls within three clock edges and the core runs with cpuClkEn, periphClkEn and oscRunEn all 1 and pinOvrEn 0.
- R2: coreRst rises only if rstPin is sampled high on at least 24 consecutive oscillator rising edges. A pulse covering 23 edges gives no reset, and one covering 24 edges gives one.
- R3: If rstPin is seen low on even one edge before the 24-edge count completes, the count starts again from zero.
- R4: Once raised, coreRst stays 1 while rstPin remains high. It returns to 0 within three edges after rstPin goes low.
- R5: machClk inverts on every oscillator rising edge outside power-down. It holds its value in power-down.
- R6: In run mode, a write with bit 0 set and bit 1 clear enters idle on that edge. Idle gives cpuClkEn 0, periphClkEn 1 and oscRunEn 1. A write with both bits clear leaves run mode unchanged.
- R7: In run mode, a write with bit 1 set enters power-down, whatever the value of bit 0. Power-down gives cpuClkEn 0, periphClkEn 0 and oscRunEn 0 while rstPin is low.
- R8: In idle, any nonzero intReq returns the core to run on the next edge. With intReq all zero, idle persists.
- R9: In power-down, intReq has no effect. Power-control writes made during idle or power-down are ignored.
- R10: A qualified reset returns the core from idle or from power-down to run mode.
- R11: In power-down, oscRunEn follows rstPin combinationally, so a rising reset pin restarts the oscillator without waiting for a clock edge.
- R12: pinOvrEn is 1 exactly in idle and power-down. aleLvl and psenLvl are both 1 in idle and both 0 in power-down.
- R13: In a low-power mode, p0Float equals extProgMem. p2Addr is 1 only in idle with extProgMem 1. Outside the low-power modes both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkOsc | input | 1 | Oscillator clock |
| powerOnRstN | input | 1 | Supply-good indication, active low, asynchronous |
| rstPin | input | 1 | Raw external reset pin, active high, asynchronous |
| pconWrEn | input | 1 | Power-control write strobe |
| pconWrData | input | 2 | Power-control value; bit 0 idle, bit 1 power-down |
| intReq | input | NUM_IRQ | Interrupt requests, already masked by their enables |
| extProgMem | input | 1 | 1 when program memory is external |
| machClk | output | 1 | Oscillator divided by two |
| cpuClkEn | output | 1 | CPU clock enable |
| periphClkEn | output | 1 | Peripheral clock enable |
| oscRunEn | output | 1 | Oscillator run enable |
| coreRst | output | 1 | Qualified core reset |
| pinOvrEn | output | 1 | Pin overrides are active (low-power mode) |
| aleLvl | output | 1 | Forced address-latch strobe level |
| psenLvl | output | 1 | Forced program-fetch strobe level |
| p0Float | output | 1 | Port 0 goes high impedance |
| p2Addr | output | 1 | Port 2 keeps its address instead of latch data |

## Verification
The checker relies on three input conditions. powerOnRstN is held low across several oscillator edges at start-up. intReq arrives already masked, so any bit set counts as a wake request. The oscillator clock keeps ticking even in power-down, with the stop represented only by oscRunEn. The bench honours all three: it supplies a free-running clock, changes every input at falling edges, and asserts the supply-good reset for three edges before releasing it. Reset pulses are swept over widths from 1 to 30 periods across the 24-edge boundary. One pattern has a single-period dropout, and every interrupt line is tried in turn as a wake source.

// File: rtl/mcu_power_pkg.sv
package mcu_power_pkg;

  typedef enum logic [1:0] {
    MODE_RUN  = 2'd0,
    MODE_IDLE = 2'd1,
    MODE_PD   = 2'd2
  } pwrMode_e;

  // Strobes from the mode control to the datapath
  typedef struct packed {
    logic inRun;
    logic inIdle;
    logic inPd;
  } ctrlStrobes_t;

  localparam int PCON_IDLE_BIT = 0;
  localparam int PCON_PD_BIT   = 1;
  localparam int PCON_WIDTH    = 2;

endpackage

// File: rtl/mcu_power_ctrl_fsm.sv
module mcu_power_ctrl_fsm
  import mcu_power_pkg::*;
#(
  parameter int NUM_IRQ = 5
) (
  input  logic                  clkOsc,
  input  logic                  powerOnRstN,
  input  logic                  coreRst,
  input  logic                  pconWrEn,
  input  logic [PCON_WIDTH-1:0] pconWrData,
  input  logic [NUM_IRQ-1:0]    intReq,
  output ctrlStrobes_t          strobes
);

  pwrMode_e modeQ, modeNext;
  logic     wakeReq;

  assign wakeReq = |intReq;

  always_comb begin
    modeNext = modeQ;
    unique case (modeQ)
      MODE_RUN: begin
        if (pconWrEn) begin
          if (pconWrData[PCON_PD_BIT]) begin
            modeNext = MODE_PD;          // power-down wins over idle
          end else if (pconWrData[PCON_IDLE_BIT]) begin
            modeNext = MODE_IDLE;
          end
        end
      end
      MODE_IDLE: begin
        if (wakeReq) begin
          modeNext = MODE_RUN;           // idle bit cleared on wake
        end
      end
      MODE_PD: begin
        modeNext = MODE_PD;              // only a reset leaves
      end
      default: modeNext = MODE_RUN;
    endcase
  end

  always_ff @(posedge clkOsc or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      modeQ <= MODE_RUN;
    end else if (coreRst) begin
      modeQ <= MODE_RUN;
    end else begin
      modeQ <= modeNext;
    end
  end

  always_comb begin
    strobes.inRun  = (modeQ == MODE_RUN);
    strobes.inIdle = (modeQ == MODE_IDLE);
    strobes.inPd   = (modeQ == MODE_PD);
  end

endmodule

// File: rtl/mcu_power_ctrl_dp.sv
module mcu_power_ctrl_dp
  import mcu_power_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int QUAL_CYCLES = 24
) (
  input  logic         clkOsc,
  input  logic         powerOnRstN,
  input  logic         rstPin,
  input  logic         extProgMem,
  input  ctrlStrobes_t strobes,
  output logic         coreRst,
  output logic         machClk,
  output logic         cpuClkEn,
  output logic         periphClkEn,
  output logic         oscRunEn,
  output logic         pinOvrEn,
  output logic         aleLvl,
  output logic         psenLvl,
  output logic         p0Float,
  output logic         p2Addr
);

  localparam int CNT_W = $clog2(QUAL_CYCLES + 1);

  // reset pin synchronizer
  logic [SYNC_STAGES-1:0] syncChain;
  logic                   syncRst;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clkOsc or negedge powerOnRstN) begin
        if (!powerOnRstN) syncChain <= '0;
        else              syncChain <= rstPin;
      end
    end else begin : g_syncN
      always_ff @(posedge clkOsc or negedge powerOnRstN) begin
        if (!powerOnRstN) syncChain <= '0;
        else              syncChain <= {syncChain[SYNC_STAGES-2:0], rstPin};
      end
    end
  endgenerate

  assign syncRst = syncChain[SYNC_STAGES-1];

  // qualification counter and reset register
  logic [CNT_W-1:0] qualCnt;
  logic             qualDone;
  logic             coreRstQ;

  assign qualDone = (qualCnt == CNT_W'(QUAL_CYCLES - 1));

  always_ff @(posedge clkOsc or negedge powerOnRstN) begin
    if (!powerOnRstN) begin
      qualCnt  <= '0;
      coreRstQ <= 1'b1;
    end else if (!syncRst) begin
      qualCnt  <= '0;
      coreRstQ <= 1'b0;
    end else if (qualDone) begin
      coreRstQ <= 1'b1;
    end else begin
      qualCnt  <= qualCnt + CNT_W'(1);
    end
  end

  assign coreRst = coreRstQ;

  // divide-by-two machine clock, frozen in power-down
  logic phaseQ;

  always_ff @(posedge clkOsc or negedge powerOnRstN) begin
    if (!powerOnRstN)      phaseQ <= 1'b0;
    else if (!strobes.inPd) phaseQ <= ~phaseQ;
  end

  assign machClk = phaseQ;

  // clock enables
  assign cpuClkEn    = strobes.inRun & ~coreRstQ;
  assign periphClkEn = ~strobes.inPd;
  assign oscRunEn    = ~strobes.inPd | rstPin;

  // pin overrides in the low-power modes
  logic lowPower;
  assign lowPower = strobes.inIdle | strobes.inPd;

  always_comb begin
    pinOvrEn = lowPower;
    aleLvl   = strobes.inIdle;
    psenLvl  = strobes.inIdle;
    p0Float  = lowPower & extProgMem;
    p2Addr   = strobes.inIdle & extProgMem;
  end

endmodule

// File: rtl/mcu_power_ctrl.sv
module mcu_power_ctrl
  import mcu_power_pkg::*;
#(
  parameter int NUM_IRQ      = 5,
  parameter int SYNC_STAGES  = 2,
  parameter int OSC_PER_MC   = 12,
  parameter int RST_MC_COUNT = 2
) (
  input  logic                  clkOsc,
  input  logic                  powerOnRstN,
  input  logic                  rstPin,
  input  logic                  pconWrEn,
  input  logic [PCON_WIDTH-1:0] pconWrData,
  input  logic [NUM_IRQ-1:0]    intReq,
  input  logic                  extProgMem,
  output logic                  machClk,
  output logic                  cpuClkEn,
  output logic                  periphClkEn,
  output logic                  oscRunEn,
  output logic                  coreRst,
  output logic                  pinOvrEn,
  output logic                  aleLvl,
  output logic                  psenLvl,
  output logic                  p0Float,
  output logic                  p2Addr
);

  localparam int QUAL_CYCLES = OSC_PER_MC * RST_MC_COUNT;

  ctrlStrobes_t strobes;

  mcu_power_ctrl_fsm #(.NUM_IRQ(NUM_IRQ)) u_fsm (
    .clkOsc      (clkOsc),
    .powerOnRstN (powerOnRstN),
    .coreRst     (coreRst),
    .pconWrEn    (pconWrEn),
    .pconWrData  (pconWrData),
    .intReq      (intReq),
    .strobes     (strobes)
  );

  mcu_power_ctrl_dp #(
    .SYNC_STAGES (SYNC_STAGES),
    .QUAL_CYCLES (QUAL_CYCLES)
  ) u_dp (
    .clkOsc      (clkOsc),
    .powerOnRstN (powerOnRstN),
    .rstPin      (rstPin),
    .extProgMem  (extProgMem),
    .strobes     (strobes),
    .coreRst     (coreRst),
    .machClk     (machClk),
    .cpuClkEn    (cpuClkEn),
    .periphClkEn (periphClkEn),
    .oscRunEn    (oscRunEn),
    .pinOvrEn    (pinOvrEn),
    .aleLvl      (aleLvl),
    .psenLvl     (psenLvl),
    .p0Float     (p0Float),
    .p2Addr      (p2Addr)
  );

endmodule

// File: rtl/mcu_power_ctrl_chk.sv
module mcu_power_ctrl_chk #(
  parameter int NUM_IRQ = 5
) (
  input logic               clkOsc,
  input logic               powerOnRstN,
  input logic               rstPin,
  input logic [NUM_IRQ-1:0] intReq,
  input logic               extProgMem,
  input logic               machClk,
  input logic               cpuClkEn,
  input logic               periphClkEn,
  input logic               oscRunEn,
  input logic               coreRst,
  input logic               pinOvrEn,
  input logic               aleLvl,
  input logic               psenLvl,
  input logic               p0Float,
  input logic               p2Addr
);

  logic inIdle;
  assign inIdle = periphClkEn & ~cpuClkEn & ~coreRst;

  AST_CPU_OFF_IN_RESET: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    coreRst |-> !cpuClkEn); // R1

  AST_MCLK_TOGGLES: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    periphClkEn |=> (machClk != $past(machClk))); // R5

  AST_MCLK_FROZEN_PD: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    !periphClkEn |=> $stable(machClk)); // R5

  AST_IDLE_WAKES: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    (inIdle && (|intReq)) |=> (cpuClkEn || coreRst)); // R8

  AST_PD_EXIT_ONLY_RESET: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    $rose(periphClkEn) |-> $past(coreRst)); // R9

  AST_OSC_FOLLOWS_PIN: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    (periphClkEn || rstPin) |-> oscRunEn); // R11

  AST_IDLE_STROBES_HIGH: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    inIdle |-> (pinOvrEn && aleLvl && psenLvl)); // R12

  AST_PD_STROBES_LOW: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    !periphClkEn |-> (pinOvrEn && !aleLvl && !psenLvl)); // R12

  AST_PORTS_RELEASED: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    !pinOvrEn |-> (!p0Float && !p2Addr)); // R13

  AST_PORT0_FLOAT: assert property (@(posedge clkOsc) disable iff (!powerOnRstN)
    pinOvrEn |-> (p0Float == extProgMem)); // R13

endmodule

bind mcu_power_ctrl mcu_power_ctrl_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clkOsc      (clkOsc),
  .powerOnRstN (powerOnRstN),
  .rstPin      (rstPin),
  .intReq      (intReq),
  .extProgMem  (extProgMem),
  .machClk     (machClk),
  .cpuClkEn    (cpuClkEn),
  .periphClkEn (periphClkEn),
  .oscRunEn    (oscRunEn),
  .coreRst     (coreRst),
  .pinOvrEn    (pinOvrEn),
  .aleLvl      (aleLvl),
  .psenLvl     (psenLvl),
  .p0Float     (p0Float),
  .p2Addr      (p2Addr)
);

// File: tb/mcu_power_ctrl_test.sv
module mcu_power_ctrl_test;

  localparam int NUM_IRQ = 5;
  localparam int QUAL    = 24;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               powerOnRstN;
  logic               rstPin;
  logic               pconWrEn;
  logic [1:0]         pconWrData;
  logic [NUM_IRQ-1:0] intReq;
  logic               extProgMem;
  logic machClk, cpuClkEn, periphClkEn, oscRunEn, coreRst;
  logic pinOvrEn, aleLvl, psenLvl, p0Float, p2Addr;

  mcu_power_ctrl #(.NUM_IRQ(NUM_IRQ)) uut (
    .clkOsc(clk), .powerOnRstN(powerOnRstN), .rstPin(rstPin),
    .pconWrEn(pconWrEn), .pconWrData(pconWrData), .intReq(intReq),
    .extProgMem(extProgMem), .machClk(machClk), .cpuClkEn(cpuClkEn),
    .periphClkEn(periphClkEn), .oscRunEn(oscRunEn), .coreRst(coreRst),
    .pinOvrEn(pinOvrEn), .aleLvl(aleLvl), .psenLvl(psenLvl),
    .p0Float(p0Float), .p2Addr(p2Addr)
  );

  int  total = 0;
  int  bad   = 0;
  bit  finished = 0;
  bit  seenAny;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic watch(input int n);
    repeat (n) begin
      @(negedge clk);
      seenAny |= coreRst;
    end
  endtask

  task automatic pconWrite(input logic [1:0] v);
    pconWrData = v;
    pconWrEn   = 1'b1;
    @(negedge clk);
    pconWrEn   = 1'b0;
  endtask

  // pin high for n rising edges, then low; atEnd = coreRst as the pin drops
  task automatic rstPulse(input int n, output bit atEnd);
    seenAny = 1'b0;
    rstPin  = 1'b1;
    watch(n);
    atEnd  = coreRst;
    rstPin = 1'b0;
    watch(8);
  endtask

  task automatic checkRunning(input string tag);
    chk(cpuClkEn == 1'b1,    tag, cpuClkEn, 1);
    chk(periphClkEn == 1'b1, tag, periphClkEn, 1);
    chk(pinOvrEn == 1'b0,    tag, pinOvrEn, 0);
  endtask

  initial begin
    bit   atEnd;
    logic prev;
    powerOnRstN = 1'b0;
    rstPin      = 1'b0;
    pconWrEn    = 1'b0;
    pconWrData  = 2'b00;
    intReq      = '0;
    extProgMem  = 1'b0;
    cyc(3);
    chk(coreRst == 1'b1,  "R1 reset held", coreRst, 1);
    chk(cpuClkEn == 1'b0, "R1 cpu off in reset", cpuClkEn, 0);
    powerOnRstN = 1'b1;
    cyc(3);
    chk(coreRst == 1'b0,  "R1 reset released", coreRst, 0);
    chk(oscRunEn == 1'b1, "R1 osc on", oscRunEn, 1);
    checkRunning("R1 run after release");

    // R5: divider toggles each edge in run
    prev = machClk;
    for (int i = 0; i < 8; i++) begin
      cyc(1);
      chk(machClk != prev, "R5 toggle run", machClk, !prev);
      prev = machClk;
    end

    // R2 / R4: sweep the pulse width across the qualification boundary
    for (int n = 1; n <= 30; n++) begin
      rstPulse(n, atEnd);
      chk(seenAny == (n >= QUAL), $sformatf("R2 width %0d", n), seenAny, n >= QUAL);
      if (n >= QUAL + 2)
        chk(atEnd == 1'b1, $sformatf("R4 held width %0d", n), atEnd, 1);
      chk(coreRst == 1'b0, $sformatf("R4 released width %0d", n), coreRst, 0);
      chk(cpuClkEn == 1'b1, $sformatf("R4 run width %0d", n), cpuClkEn, 1);
    end

    // R3: a one-period dropout restarts the count
    seenAny = 1'b0;
    rstPin = 1'b1; watch(20);
    rstPin = 1'b0; watch(1);
    rstPin = 1'b1; watch(20);
    rstPin = 1'b0; watch(8);
    chk(seenAny == 1'b0, "R3 dropout 20+20", seenAny, 0);
    seenAny = 1'b0;
    rstPin = 1'b1; watch(20);
    rstPin = 1'b0; watch(1);
    rstPin = 1'b1; watch(QUAL);
    rstPin = 1'b0; watch(8);
    chk(seenAny == 1'b1, "R3 dropout 20+24", seenAny, 1);

    // R6: zero write keeps run, bit 0 write enters idle
    pconWrite(2'b00);
    checkRunning("R6 zero write");
    pconWrite(2'b01);
    chk(cpuClkEn == 1'b0,    "R6 idle cpu", cpuClkEn, 0);
    chk(periphClkEn == 1'b1, "R6 idle periph", periphClkEn, 1);
    chk(oscRunEn == 1'b1,    "R6 idle osc", oscRunEn, 1);
    chk(pinOvrEn && aleLvl && psenLvl, "R12 idle strobes high", {pinOvrEn, aleLvl, psenLvl}, 7);
    for (int e = 0; e < 2; e++) begin
      extProgMem = e[0];
      #2;
      chk(p0Float == e[0], $sformatf("R13 idle p0 ext=%0d", e), p0Float, e);
      chk(p2Addr == e[0],  $sformatf("R13 idle p2 ext=%0d", e), p2Addr, e);
    end
    prev = machClk;
    cyc(1);
    chk(machClk != prev, "R5 toggle idle", machClk, !prev);
    cyc(5);
    chk(cpuClkEn == 1'b0, "R8 idle holds without irq", cpuClkEn, 0);
    pconWrite(2'b10);
    chk(periphClkEn == 1'b1 && cpuClkEn == 1'b0, "R9 write ignored in idle",
        {periphClkEn, cpuClkEn}, 2);

    // R8: every request line wakes idle
    for (int k = 0; k < NUM_IRQ; k++) begin
      if (cpuClkEn) pconWrite(2'b01);
      intReq = NUM_IRQ'(1) << k;
      cyc(1);
      intReq = '0;
      chk(cpuClkEn == 1'b1, $sformatf("R8 wake line %0d", k), cpuClkEn, 1);
      chk(pinOvrEn == 1'b0, $sformatf("R12 ovr off line %0d", k), pinOvrEn, 0);
    end

    // R7: both bits set picks power-down
    pconWrite(2'b11);
    chk(periphClkEn == 1'b0, "R7 pd periph", periphClkEn, 0);
    chk(cpuClkEn == 1'b0,    "R7 pd cpu", cpuClkEn, 0);
    chk(oscRunEn == 1'b0,    "R7 pd osc", oscRunEn, 0);
    chk(pinOvrEn && !aleLvl && !psenLvl, "R12 pd strobes low", {pinOvrEn, aleLvl, psenLvl}, 4);
    for (int e = 0; e < 2; e++) begin
      extProgMem = e[0];
      #2;
      chk(p0Float == e[0], $sformatf("R13 pd p0 ext=%0d", e), p0Float, e);
      chk(p2Addr == 1'b0,  $sformatf("R13 pd p2 ext=%0d", e), p2Addr, 0);
    end
    prev = machClk;
    cyc(4);
    chk(machClk == prev, "R5 frozen pd", machClk, prev);
    intReq = '1;
    cyc(5);
    intReq = '0;
    chk(periphClkEn == 1'b0, "R9 irq ignored in pd", periphClkEn, 0);
    pconWrite(2'b01);
    chk(periphClkEn == 1'b0, "R9 write ignored in pd", periphClkEn, 0);

    // R11: raw pin restarts the oscillator without a clock edge
    rstPin = 1'b1;
    #2;
    chk(oscRunEn == 1'b1, "R11 pin high osc", oscRunEn, 1);
    rstPin = 1'b0;
    #2;
    chk(oscRunEn == 1'b0, "R11 pin low osc", oscRunEn, 0);
    cyc(1);

    // R10: reset leaves power-down
    rstPulse(QUAL + 2, atEnd);
    chk(seenAny == 1'b1, "R10 reset seen in pd", seenAny, 1);
    checkRunning("R10 run after pd");

    // R7: bit 1 alone
    pconWrite(2'b10);
    chk(periphClkEn == 1'b0, "R7 pd single bit", periphClkEn, 0);
    rstPulse(30, atEnd);
    checkRunning("R10 run after pd single bit");

    // R10: reset leaves idle
    pconWrite(2'b01);
    rstPulse(QUAL + 2, atEnd);
    chk(seenAny == 1'b1, "R10 reset seen in idle", seenAny, 1);
    checkRunning("R10 run after idle");

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule